// File: doc/BRIEF.md
# Colour Sensor Bring-up Sequencer

This block runs on the host side of a two-wire bus and drives an RGB colour sensor from power-on to a finished reading. It does not toggle the bus wires itself. Instead it hands byte-level commands (START, WRITE byte, READ byte, STOP) to a separate bus master and waits for one response per command. A single `start` pulse runs a fixed script. The script holds the sensor's reset line low, writes the five mandatory setup registers, and programs the per-channel photodiode size and integration time from input ports. It then fires an acquisition and polls the trigger register until it reads zero. Last, it reads back the red, green and blue results.

The three result bytes appear together on a valid/ready output. The sequencer holds `res_valid` and the data steady until the consumer raises `res_ready`, so a slow consumer only delays the end of the run. The command and response channels to the bus master are also valid/ready. Only one command is in flight at a time: the sequencer issues the next command only after it has taken the previous response. Two cases abort the run: a not-acknowledge on any written byte, or a poll count that runs out. In both cases the sequencer raises `err`, and `err_timeout` records which of the two occurred.

Top module: `rgb_sensor_seq`

## Requirements
- R1: An accepted `start` drives `sensor_rst_n` low for exactly RST_CYCLES = ceil(CLK_KHZ*RST_NS/1e6) clock cycles, with a minimum of one. No command is accepted by the bus master while `sensor_rst_n` is low.
- R2: After the reset pulse, the sequencer writes 0x01 to sensor registers 0x03, 0x04, 0x0C, 0x0D and 0x0E, in that order. Each write is the command string START, WRITE 0xB0 (device 0x58 with direction bit 0), WRITE register, WRITE data, STOP.
- R3: Next come six gain writes. The photodiode sizes go to 0x0B, 0x0A and 0x09 (red, green, blue), then the integration times go to 0x11, 0x10 and 0x0F (red, green, blue). The values are the `pd_*`/`ti_*` inputs captured in the cycle `start` is accepted.
- R4: The sequencer then writes 0x02 to register 0x02 and polls register 0x02 with reads until a read returns 0x00. A read is START, WRITE 0xB0, WRITE register, START, WRITE 0xB1, READ (with `cmd_rd_nack`=1 so the master not-acknowledges), STOP.
- R5: If max(`poll_limit`,1) consecutive poll reads return non-zero, the run ends with `err`=1, `err_timeout`=1 and `busy`=0, and no further commands are issued.
- R6: After a zero poll, the sequencer reads 0x44, 0x43 and 0x42 into `res_red`, `res_grn` and `res_blu`. `res_valid` and the data stay stable until `res_ready`. `busy` and `res_valid` fall in the cycle after the handshake.
- R7: A WRITE response with `rsp_nack`=1 makes the next command a STOP. The run then ends with `err`=1, `err_timeout`=0 and `busy`=0, and no later transaction is issued.
- R8: `busy` rises in the cycle after a `start` is accepted and stays high until the run ends. A `start` pulse while `busy` is high is ignored: no new reset pulse is issued and the script is not altered.
- R9: Command encoding on `cmd_op`: 0 START, 1 WRITE, 2 READ, 3 STOP. `cmd_valid` holds with a stable op and data until `cmd_ready`. The next command follows only after the response is taken, and `rsp_ready` is high only while a response is awaited.
- R10: After reset: `sensor_rst_n`=1, `busy`=0, `err`=0, `cmd_valid`=0 and `res_valid`=0. An accepted `start` clears `err` and `err_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| pd_red | input | 8 | Red photodiode size value |
| pd_grn | input | 8 | Green photodiode size value |
| pd_blu | input | 8 | Blue photodiode size value |
| ti_red | input | 8 | Red integration time value |
| ti_grn | input | 8 | Green integration time value |
| ti_blu | input | 8 | Blue integration time value |
| poll_limit | input | LIM_W | Maximum number of non-zero poll reads (0 acts as 1) |
| sensor_rst_n | output | 1 | Active-low hardware reset to the sensor |
| cmd_valid | output | 1 | Command to the bus master is valid |
| cmd_ready | input | 1 | Bus master takes the command |
| cmd_op | output | 2 | Command kind: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_data | output | 8 | Byte for a WRITE command |
| cmd_rd_nack | output | 1 | Master not-acknowledges the byte of this READ |
| rsp_valid | input | 1 | Response from the bus master is valid |
| rsp_ready | output | 1 | Sequencer takes the response |
| rsp_nack | input | 1 | Written byte was not acknowledged |
| rsp_data | input | 8 | Byte returned by a READ |
| res_valid | output | 1 | Colour result is valid |
| res_ready | input | 1 | Consumer takes the result |
| res_red | output | 8 | Red channel result |
| res_grn | output | 8 | Green channel result |
| res_blu | output | 8 | Blue channel result |
| busy | output | 1 | A run is in progress |
| err | output | 1 | Last run aborted |
| err_timeout | output | 1 | Abort cause: 1 poll timeout, 0 not-acknowledge |

## Verification
The script is run with distinct gain and result values, so a swapped channel or register shows up as a mismatch in the scoreboard. Poll counts of zero, two and the limit exactly separate the success and timeout boundaries, including a limit of zero. Not-acknowledges are injected both on an address byte and on a data byte in the gain phase, which tests the STOP-then-abort path at two depths in the script. Slow command acceptance, delayed responses, a late `res_ready` and a `start` pulse in mid-run check that back-pressure and ignored starts leave the transaction order unchanged.

// File: rtl/rgb_seq_pkg.sv
package rgb_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  localparam logic [6:0] DEV_ADDR = 7'h58;

  localparam int STEP_W = 4;
  typedef logic [STEP_W-1:0] step_t;

  // script layout: setup writes, gain writes, trigger, poll, three readbacks
  localparam int    N_SETUP    = 5;
  localparam int    N_GAIN     = 6;
  localparam step_t STEP_GAIN0 = step_t'(N_SETUP);
  localparam step_t STEP_TRIG  = step_t'(N_SETUP + N_GAIN);
  localparam step_t STEP_POLL  = step_t'(N_SETUP + N_GAIN + 1);
  localparam step_t STEP_RD0   = step_t'(N_SETUP + N_GAIN + 2);
  localparam step_t STEP_LAST  = step_t'(N_SETUP + N_GAIN + 4);

  localparam logic [7:0] SETUP_VAL = 8'h01;
  localparam logic [7:0] TRIG_VAL  = 8'h02;

  function automatic logic [7:0] step_reg(step_t s);
    logic [7:0] r;
    case (s)
      4'd0:    r = 8'h03;
      4'd1:    r = 8'h04;
      4'd2:    r = 8'h0C;
      4'd3:    r = 8'h0D;
      4'd4:    r = 8'h0E;
      4'd5:    r = 8'h0B;
      4'd6:    r = 8'h0A;
      4'd7:    r = 8'h09;
      4'd8:    r = 8'h11;
      4'd9:    r = 8'h10;
      4'd10:   r = 8'h0F;
      4'd11:   r = 8'h02;
      4'd12:   r = 8'h02;
      4'd13:   r = 8'h44;
      4'd14:   r = 8'h43;
      default: r = 8'h42;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rgb_rst_pulse.sv
module rgb_rst_pulse #(
  parameter int CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pin_n,
  output logic released
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_n    <= 1'b1;
      left     <= '0;
      released <= 1'b0;
    end else begin
      released <= 1'b0;
      if (pin_n) begin
        if (fire) begin
          pin_n <= 1'b0;
          left  <= CW'(CYCLES - 1);
        end
      end else if (left == '0) begin
        pin_n    <= 1'b1;
        released <= 1'b1;
      end else begin
        left <= left - CW'(1);
      end
    end
  end
endmodule

// File: rtl/rgb_poll_timer.sv
module rgb_poll_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt;
  logic [W:0]   lim_eff;

  assign lim_eff = (limit == '0) ? (W+1)'(1) : {1'b0, limit};
  assign last    = ({1'b0, cnt} + (W+1)'(1)) >= lim_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (tick && !last)  cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/rgb_reg_xact.sv
module rgb_reg_xact
  import rgb_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       go_rd,
  input  logic [7:0] go_reg,
  input  logic [7:0] go_dat,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_data,
  output logic       cmd_rd_nack,
  input  logic       rsp_valid,
  output logic       rsp_ready,
  input  logic       rsp_nack,
  input  logic [7:0] rsp_data,
  output logic       done,
  output logic       nack,
  output logic [7:0] rdata
);
  typedef enum logic [1:0] {X_IDLE, X_CMD, X_RSP} xact_state_e;

  localparam int MU_W = 3;

  xact_state_e xs;
  logic [MU_W-1:0] mu, stop_mu;
  logic       rd_q;
  logic [7:0] reg_q, dat_q;
  bus_op_e    op;
  logic [7:0] byte_o;

  assign stop_mu = rd_q ? MU_W'(6) : MU_W'(4);

  always_comb begin
    op     = OP_STOP;
    byte_o = 8'h00;
    if (!rd_q) begin
      case (mu)
        3'd0: op = OP_START;
        3'd1: begin op = OP_WRITE; byte_o = {DEV_ADDR, 1'b0}; end
        3'd2: begin op = OP_WRITE; byte_o = reg_q; end
        3'd3: begin op = OP_WRITE; byte_o = dat_q; end
        default: op = OP_STOP;
      endcase
    end else begin
      case (mu)
        3'd0: op = OP_START;
        3'd1: begin op = OP_WRITE; byte_o = {DEV_ADDR, 1'b0}; end
        3'd2: begin op = OP_WRITE; byte_o = reg_q; end
        3'd3: op = OP_START;
        3'd4: begin op = OP_WRITE; byte_o = {DEV_ADDR, 1'b1}; end
        3'd5: op = OP_READ;
        default: op = OP_STOP;
      endcase
    end
  end

  assign cmd_valid   = (xs == X_CMD);
  assign rsp_ready   = (xs == X_RSP);
  assign cmd_op      = op;
  assign cmd_data    = byte_o;
  assign cmd_rd_nack = (op == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs    <= X_IDLE;
      mu    <= '0;
      rd_q  <= 1'b0;
      reg_q <= '0;
      dat_q <= '0;
      nack  <= 1'b0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      case (xs)
        X_IDLE: if (go) begin
          rd_q  <= go_rd;
          reg_q <= go_reg;
          dat_q <= go_dat;
          mu    <= '0;
          nack  <= 1'b0;
          xs    <= X_CMD;
        end
        X_CMD: if (cmd_ready) xs <= X_RSP;
        X_RSP: if (rsp_valid) begin
          if (op == OP_READ) rdata <= rsp_data;
          if (op == OP_WRITE && rsp_nack) begin
            nack <= 1'b1;
            mu   <= stop_mu;
            xs   <= X_CMD;
          end else if (mu == stop_mu) begin
            done <= 1'b1;
            xs   <= X_IDLE;
          end else begin
            mu <= mu + MU_W'(1);
            xs <= X_CMD;
          end
        end
        default: xs <= X_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rgb_sensor_seq.sv
module rgb_sensor_seq
  import rgb_seq_pkg::*;
#(
  parameter int CLK_KHZ = 50000,
  parameter int RST_NS  = 1000,
  parameter int LIM_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       pd_red,
  input  logic [7:0]       pd_grn,
  input  logic [7:0]       pd_blu,
  input  logic [7:0]       ti_red,
  input  logic [7:0]       ti_grn,
  input  logic [7:0]       ti_blu,
  input  logic [LIM_W-1:0] poll_limit,
  output logic             sensor_rst_n,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_data,
  output logic             cmd_rd_nack,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic             rsp_nack,
  input  logic [7:0]       rsp_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [7:0]       res_red,
  output logic [7:0]       res_grn,
  output logic [7:0]       res_blu,
  output logic             busy,
  output logic             err,
  output logic             err_timeout
);
  localparam longint RAW_CYC    = (longint'(CLK_KHZ) * RST_NS + 999_999) / 1_000_000;
  localparam int     RST_CYCLES = (RAW_CYC < 1) ? 1 : int'(RAW_CYC);

  typedef enum logic [2:0] {T_IDLE, T_RST, T_GO, T_WAIT, T_OUT} top_state_e;

  top_state_e st;
  step_t      step;
  logic [N_GAIN-1:0][7:0] gain_q;

  logic       accept, rst_done;
  logic       x_go, x_rd, x_done, x_nack;
  logic [7:0] x_reg, x_dat, x_rdata;
  logic       step_ok, poll_busy, poll_tick, poll_last;
  logic [2:0] gidx;

  assign accept = (st == T_IDLE) && start;

  rgb_rst_pulse #(.CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .fire(accept),
    .pin_n(sensor_rst_n), .released(rst_done)
  );

  // per-step transaction parameters
  assign gidx = 3'(step - STEP_GAIN0);
  always_comb begin
    x_reg = step_reg(step);
    x_rd  = (step >= STEP_POLL);
    if (step < STEP_GAIN0)      x_dat = SETUP_VAL;
    else if (step < STEP_TRIG)  x_dat = (gidx < 3'(N_GAIN)) ? gain_q[gidx] : 8'h00;
    else if (step == STEP_TRIG) x_dat = TRIG_VAL;
    else                        x_dat = 8'h00;
  end

  assign x_go = (st == T_GO);

  rgb_reg_xact u_xact (
    .clk(clk), .rst_n(rst_n),
    .go(x_go), .go_rd(x_rd), .go_reg(x_reg), .go_dat(x_dat),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_rd_nack(cmd_rd_nack),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_nack(rsp_nack),
    .rsp_data(rsp_data),
    .done(x_done), .nack(x_nack), .rdata(x_rdata)
  );

  assign step_ok   = (st == T_WAIT) && x_done && !x_nack;
  assign poll_busy = (step == STEP_POLL) && (x_rdata != 8'h00);
  assign poll_tick = step_ok && poll_busy;

  rgb_poll_timer #(.W(LIM_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(accept), .tick(poll_tick),
    .limit(poll_limit), .last(poll_last)
  );

  // one capture register per colour channel
  for (genvar c = 0; c < 3; c++) begin : g_chan
    logic [7:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       val <= '0;
      else if (step_ok && step == step_t'(STEP_RD0 + c)) val <= x_rdata;
    end
  end

  assign res_red = g_chan[0].val;
  assign res_grn = g_chan[1].val;
  assign res_blu = g_chan[2].val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= T_IDLE;
      step        <= '0;
      gain_q      <= '0;
      busy        <= 1'b0;
      err         <= 1'b0;
      err_timeout <= 1'b0;
      res_valid   <= 1'b0;
    end else begin
      case (st)
        T_IDLE: if (start) begin
          busy        <= 1'b1;
          err         <= 1'b0;
          err_timeout <= 1'b0;
          step        <= '0;
          gain_q      <= {ti_blu, ti_grn, ti_red, pd_blu, pd_grn, pd_red};
          st          <= T_RST;
        end
        T_RST: if (rst_done) st <= T_GO;
        T_GO:  st <= T_WAIT;
        T_WAIT: if (x_done) begin
          if (x_nack) begin
            err  <= 1'b1;
            busy <= 1'b0;
            st   <= T_IDLE;
          end else if (poll_busy) begin
            if (poll_last) begin
              err         <= 1'b1;
              err_timeout <= 1'b1;
              busy        <= 1'b0;
              st          <= T_IDLE;
            end else begin
              st <= T_GO;
            end
          end else if (step == STEP_LAST) begin
            res_valid <= 1'b1;
            st        <= T_OUT;
          end else begin
            step <= step + step_t'(1);
            st   <= T_GO;
          end
        end
        T_OUT: if (res_ready) begin
          res_valid <= 1'b0;
          busy      <= 1'b0;
          st        <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rgb_sensor_seq_chk.sv
module rgb_sensor_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sensor_rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       rsp_ready,
  input logic       res_valid,
  input logic       res_ready,
  input logic [7:0] res_red,
  input logic [7:0] res_grn,
  input logic [7:0] res_blu,
  input logic       busy,
  input logic       err
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sensor_rst_n |-> !cmd_valid);

  // R8
  rst_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sensor_rst_n |-> busy);

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !cmd_valid);

  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable({res_red, res_grn, res_blu}));

  // R6
  res_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !cmd_valid);
endmodule

bind rgb_sensor_seq rgb_sensor_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sensor_rst_n(sensor_rst_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_data(cmd_data), .rsp_ready(rsp_ready),
  .res_valid(res_valid), .res_ready(res_ready),
  .res_red(res_red), .res_grn(res_grn), .res_blu(res_blu),
  .busy(busy), .err(err)
);

// File: tb/rgb_sensor_seq_bench.sv
module rgb_sensor_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_RST    = 10;   // 10000 kHz * 1000 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] pd_red = 0, pd_grn = 0, pd_blu = 0, ti_red = 0, ti_grn = 0, ti_blu = 0;
  logic [15:0] poll_limit = 16'd1;
  logic sensor_rst_n, cmd_valid, cmd_rd_nack, rsp_ready, res_valid, busy, err, err_timeout;
  logic cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data, res_red, res_grn, res_blu;
  logic rsp_valid = 1'b0, rsp_nack = 1'b0, res_ready = 1'b0;
  logic [7:0] rsp_data = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_sensor_seq #(.CLK_KHZ(10000), .RST_NS(1000), .LIM_W(16)) u_rgb_sensor_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pd_red(pd_red), .pd_grn(pd_grn), .pd_blu(pd_blu),
    .ti_red(ti_red), .ti_grn(ti_grn), .ti_blu(ti_blu),
    .poll_limit(poll_limit), .sensor_rst_n(sensor_rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_rd_nack(cmd_rd_nack),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_nack(rsp_nack),
    .rsp_data(rsp_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_red(res_red), .res_grn(res_grn), .res_blu(res_blu),
    .busy(busy), .err(err), .err_timeout(err_timeout)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed { logic rd; logic [7:0] rg; logic [7:0] dt; } xfer_t;
  xfer_t exp_q[$];

  // sensor / bus-master model configuration (set by the driver)
  int cfg_busy_polls = 0;
  int cfg_nack_at    = 0;
  int cfg_delay      = 0;
  bit cfg_stall      = 0;
  logic [7:0] rv_r = 0, rv_g = 0, rv_b = 0;

  // model state
  int cyc = 0, wr_cnt = 0, trig_left = 0, lowcnt = 0, last_w = 0, pulses = 0, cmd_total = 0;
  int phase = 0;          // 0 none, 1 addr, 2 ptr, 3 wdata, 4 rdata
  logic [7:0] ptr = 0;
  bit pend = 0, p_nack = 0, rsp_taken = 0, want_stop = 0;
  logic [7:0] p_data = 0;
  int dly = 0;

  task automatic sb_event(input logic rd, input logic [7:0] rg, input logic [7:0] dt);
    xfer_t got, e;
    got = '{rd, rg, dt};
    if (exp_q.size() == 0) begin
      chk(0, "R3 unexpected transaction", got, 0);
    end else begin
      e = exp_q.pop_front();
      chk(got == e, rd ? "R4 read txn" : "R2 write txn", got, e);
    end
  endtask

  task automatic handle_cmd();
    logic [7:0] v;
    p_nack = 0;
    p_data = 8'h00;
    cmd_total++;
    if (!sensor_rst_n) chk(0, "R1 command during reset", cmd_op, 0);
    if (want_stop) begin
      chk(cmd_op == 2'd3, "R7 stop after nack", cmd_op, 3);
      want_stop = 0;
    end
    case (cmd_op)
      2'd0: phase = 1;
      2'd1: begin
        wr_cnt++;
        if (wr_cnt == cfg_nack_at) begin
          p_nack = 1; want_stop = 1; phase = 0;
        end else begin
          case (phase)
            1: begin
              if (cmd_data[7:1] != 7'h58) chk(0, "R2 device address", cmd_data[7:1], 8'h58);
              phase = cmd_data[0] ? 4 : 2;
            end
            2: begin ptr = cmd_data; phase = 3; end
            3: begin
              sb_event(1'b0, ptr, cmd_data);
              if (ptr == 8'h02 && cmd_data == 8'h02) trig_left = cfg_busy_polls;
              phase = 0;
            end
            default: chk(0, "R2 stray write byte", cmd_data, 0);
          endcase
        end
      end
      2'd2: begin
        if (phase != 4 || !cmd_rd_nack) chk(0, "R4 read framing", phase, 4);
        case (ptr)
          8'h02: begin
            if (trig_left > 0) begin v = 8'h02; trig_left--; end
            else v = 8'h00;
          end
          8'h44: v = rv_r;
          8'h43: v = rv_g;
          8'h42: v = rv_b;
          default: v = 8'h00;
        endcase
        p_data = v;
        sb_event(1'b1, ptr, v);
        phase = 0;
      end
      default: phase = 0;
    endcase
  endtask

  // monitor: bus master and sensor model, driven at falling edges
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!sensor_rst_n) begin
        lowcnt++; wr_cnt = 0; phase = 0;
      end else if (lowcnt > 0) begin
        last_w = lowcnt; pulses++; lowcnt = 0;
      end
      if (rsp_taken) begin rsp_valid = 0; rsp_nack = 0; rsp_taken = 0; end
      if (pend) begin
        if (dly > 0) dly--;
        else begin rsp_valid = 1; rsp_nack = p_nack; rsp_data = p_data; pend = 0; end
      end
      if (rsp_valid && rsp_ready) rsp_taken = 1;
      cmd_ready = !(cfg_stall && (cyc % 3 == 0));
      if (cmd_valid && (pend || rsp_valid)) chk(0, "R9 command while response open", 1, 0);
      if (cmd_valid && cmd_ready) begin
        handle_cmd();
        pend = 1; dly = cfg_delay;
      end
    end
  end

  // driver: push the expected script, then run it
  task automatic do_run(input logic [47:0] gv, input logic [23:0] rv, input int bpolls,
                        input int lim, input int nack_at, input int rdy_dly,
                        input bit ok, input bit to_err, input bit poke);
    xfer_t full[$];
    logic [7:0] wr_regs[12];
    int npoll, keep, p0, c0;
    bit seen;
    logic [7:0] g[6];
    wr_regs = '{8'h03, 8'h04, 8'h0C, 8'h0D, 8'h0E, 8'h0B, 8'h0A, 8'h09, 8'h11, 8'h10, 8'h0F, 8'h02};
    for (int i = 0; i < 6; i++) g[i] = gv[47 - 8*i -: 8];
    for (int i = 0; i < 12; i++)
      full.push_back('{1'b0, wr_regs[i], (i < 5) ? 8'h01 : (i < 11) ? g[i-5] : 8'h02});
    npoll = ok ? bpolls + 1 : ((lim == 0) ? 1 : lim);
    for (int i = 0; i < npoll; i++)
      full.push_back('{1'b1, 8'h02, (i < bpolls) ? 8'h02 : 8'h00});
    if (ok) begin
      full.push_back('{1'b1, 8'h44, rv[23:16]});
      full.push_back('{1'b1, 8'h43, rv[15:8]});
      full.push_back('{1'b1, 8'h42, rv[7:0]});
    end
    keep = (nack_at > 0) ? (nack_at - 1) / 3 : full.size();
    for (int i = 0; i < keep; i++) exp_q.push_back(full[i]);

    cfg_busy_polls = bpolls; cfg_nack_at = nack_at;
    {rv_r, rv_g, rv_b} = rv;
    {pd_red, pd_grn, pd_blu, ti_red, ti_grn, ti_blu} = gv;
    poll_limit = 16'(lim);
    p0 = pulses;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    {pd_red, pd_grn, pd_blu, ti_red, ti_grn, ti_blu} = ~gv;   // R3 values captured at start
    chk(busy == 1, "R8 busy after start", busy, 1);
    chk(err == 0 && err_timeout == 0, "R10 error cleared by start", {err, err_timeout}, 0);

    seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      start = (poke && (i == 30 || i == 200));
      if (ok ? res_valid : !busy) seen = 1;
    end
    start = 0;
    chk(seen, "R6 run completion", seen, 1);
    if (ok) begin
      chk({res_red, res_grn, res_blu} == rv, "R6 result channels", {res_red, res_grn, res_blu}, rv);
      for (int i = 0; i < rdy_dly; i++) begin
        @(negedge clk);
        chk(res_valid && {res_red, res_grn, res_blu} == rv && busy, "R6 result held",
            {res_valid, res_red, res_grn, res_blu}, {1'b1, rv});
      end
      res_ready = 1;
      @(negedge clk);
      res_ready = 0;
      chk(!busy && !res_valid && !err, "R6 release after handshake", {busy, res_valid, err}, 0);
    end else begin
      chk(err == 1 && err_timeout == to_err, to_err ? "R5 timeout flags" : "R7 nack flags",
          {err, err_timeout}, {1'b1, to_err});
    end
    c0 = cmd_total;
    repeat (20) @(negedge clk);
    chk(cmd_total == c0, ok ? "R8 quiet after run" : (to_err ? "R5 quiet after abort" : "R7 quiet after abort"),
        cmd_total - c0, 0);
    chk(exp_q.size() == 0, "R3 all expected transactions seen", exp_q.size(), 0);
    exp_q.delete();
    chk(pulses == p0 + 1, "R8 single reset pulse", pulses - p0, 1);
    chk(last_w == EXP_RST, "R1 reset pulse width", last_w, EXP_RST);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sensor_rst_n && !busy && !err && !cmd_valid && !res_valid, "R10 reset state",
        {sensor_rst_n, busy, err, cmd_valid, res_valid}, 5'b10000);

    // R2 R3 R4 R6 R8: nominal run, late consumer, ignored starts
    do_run(48'h0F_07_03_05_09_0C, 24'h5A_33_71, 2, 5, 0, 4, 1, 0, 1);
    // R9: stalled command acceptance and slow responses, trigger clears at once
    cfg_stall = 1; cfg_delay = 2;
    do_run(48'h01_03_07_0E_0D_0B, 24'h12_7F_00, 0, 3, 0, 0, 1, 0, 0);
    cfg_stall = 0; cfg_delay = 0;
    // R5: poll never clears within the limit
    do_run(48'h07_07_07_07_07_07, 24'h00_00_00, 10, 3, 0, 0, 0, 1, 0);
    // R7: nack on the address byte of the third setup write
    do_run(48'h07_07_07_07_07_07, 24'h00_00_00, 0, 3, 7, 0, 0, 0, 0);
    // R7: nack on the green photodiode data byte
    cfg_delay = 1;
    do_run(48'h0A_0B_0C_0D_0E_0F, 24'h00_00_00, 0, 3, 21, 0, 0, 0, 0);
    cfg_delay = 0;
    // R10 R5: error cleared; limit 1 with an immediately idle trigger succeeds
    do_run(48'h03_01_0F_02_04_06, 24'h44_55_66, 0, 1, 0, 1, 1, 0, 0);
    // R5: limit 1 with one busy poll times out
    do_run(48'h03_01_0F_02_04_06, 24'h00_00_00, 1, 1, 0, 0, 0, 1, 0);
    // R5: limit 0 behaves as 1
    do_run(48'h03_01_0F_02_04_06, 24'h00_00_00, 1, 0, 0, 0, 0, 1, 0);
    // R4: busy polls one below the limit still succeed
    do_run(48'h0F_0F_0F_10_10_10, 24'h7F_01_40, 3, 4, 0, 2, 1, 0, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule